// File: doc/BRIEF.md
# Pin interrupt source selector

This block turns a wide bus of GPIO interrupt lines into a bank of 32 interrupt channels. Each channel is routed at run time to any one of up to 128 lines. It watches that line with its own sense mode, which is one of rising edge, falling edge, high level or low level. When the chosen condition occurs, the channel latches a status bit. Each status bit drives an active-high request line towards the parent interrupt controller.

Software programs the block through a simple word-addressed register port.

- **Routing:** an 8-bit select field per channel gives a line index and an enable bit. Four select fields are packed into each 32-bit word.
- **Sense mode:** a 2-bit sense field per channel. Sixteen sense fields are packed into each word, so two words cover the bank.
- **Acknowledge:** software writes the status word back with a 0 in the bit of each channel it has serviced.

Channels that are disabled, or that have just had their source changed, reload their edge history so that the change itself never counts as an edge.

Top module: `pirq_router`

## Requirements
- R1: While `rst` is high at a rising clock edge, every select, sense and status bit is zero, `irq_out` reads zero on the next cycle, and every register word reads back zero.
- R2: Register words are addressed by word index: sense words at 0x08 and 0x09, status at 0x0A, select words at 0x0C+k for k = 0..7. Select and sense words read back the value last written. An unmapped word index reads zero.
- R3: The select field of channel c is bits 8*(c%4)+7 : 8*(c%4) of select word 0x0C + c/4. Its bit 7 enables the channel and bits 6:0 choose the GPIO line. A channel whose enable bit is 0 never sets its status bit, whatever its line does.
- R4: Sense code 0 (rising edge) sets status at the first clock edge where the selected line is 1 and the line was 0 at the previous edge.
- R5: Sense code 1 (falling edge) sets status at the first clock edge where the selected line is 0 and the line was 1 at the previous edge. A rising transition has no effect in this mode.
- R6: Sense code 2 (high level) sets status at every clock edge where the selected line is 1, so a cleared status bit sets again while the line stays high.
- R7: Sense code 3 (low level) sets status at every clock edge where the selected line is 0. Once set, status stays set after the line returns high, until it is cleared.
- R8: Writing word 0x0A clears each status bit whose written data bit is 0. A written 1 leaves that status bit unchanged.
- R9: When a channel's event and a clearing write to word 0x0A fall in the same cycle, the status bit ends set.
- R10: Enabling a channel in an edge mode while its line is already at the active level does not set status. Switching an enabled channel to a new line that sits at a different level does not set status.
- R11: `irq_out[c]` is high exactly when status bit c is set, and reading word 0x0A returns the same vector.
- R12: The sense field of channel c < 16 is bits 2c+1:2c of word 0x08. The sense field of channel c >= 16 is bits 2(c-16)+1:2(c-16) of word 0x09.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| gpio_in | input | 128 | GPIO interrupt lines, synchronous to `clk` |
| irq_out | output | 32 | Active-high interrupt requests, one per channel |

## Verification
The assertions take for granted that the GPIO lines are already synchronous to `clk` and carry no unknown values. They also assume reset is held for several cycles before any activity, so the history and status state start from known values. The stimulus keeps within these assumptions: it changes GPIO lines and drives register writes only on falling clock edges, holds each write for exactly one cycle, and releases reset only after four cycles. Within those limits the properties check that a status bit rises only after a channel event, survives every write that does not clear it, and is never lost to a same-cycle clear.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

    localparam int unsigned WORD_AW   = 6;
    localparam int unsigned MAX_LINES = 128;
    localparam int unsigned SRC_W     = 7;

    localparam logic [WORD_AW-1:0] W_SNS0 = 6'h08;
    localparam logic [WORD_AW-1:0] W_STAT = 6'h0A;
    localparam logic [WORD_AW-1:0] W_SEL0 = 6'h0C;

    typedef enum logic [1:0] {
        SNS_RISE = 2'd0,
        SNS_FALL = 2'd1,
        SNS_HIGH = 2'd2,
        SNS_LOW  = 2'd3
    } sense_e;

    typedef struct packed {
        logic             en;
        logic [SRC_W-1:0] src;
    } sel_t;

    // Event decision for one channel in one cycle.
    function automatic logic sense_hit(sense_e mode, logic en, logic armed,
                                       logic cur, logic prev);
        logic hit;
        case (mode)
            SNS_RISE: hit = armed & cur & ~prev;
            SNS_FALL: hit = armed & ~cur & prev;
            SNS_HIGH: hit = en & cur;
            SNS_LOW:  hit = en & ~cur;
            default:  hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/pirq_regs.sv
module pirq_regs
    import pirq_pkg::*;
#(
    parameter int NUM_CH = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [WORD_AW-1:0]        word,
    input  logic [31:0]               wdata,
    input  logic [NUM_CH-1:0]         stat_i,
    output logic [31:0]               rdata,
    output logic                      stat_we,
    output sel_t [NUM_CH-1:0]         sel_o,
    output logic [NUM_CH-1:0][1:0]    sense_o
);

    localparam int NUM_SEL = (NUM_CH + 3) / 4;
    localparam int NUM_SNS = (NUM_CH + 15) / 16;

    logic [NUM_SEL-1:0][31:0] sel_q;
    logic [NUM_SNS-1:0][31:0] sns_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            sns_q <= '0;
        end else if (wr_en) begin
            for (int k = 0; k < NUM_SEL; k++) begin
                if (word == W_SEL0 + WORD_AW'(k)) sel_q[k] <= wdata;
            end
            for (int s = 0; s < NUM_SNS; s++) begin
                if (word == W_SNS0 + WORD_AW'(s)) sns_q[s] <= wdata;
            end
        end
    end

    assign stat_we = wr_en && (word == W_STAT);

    always_comb begin
        rdata = '0;
        if (word == W_STAT) rdata = 32'(stat_i);
        for (int k = 0; k < NUM_SEL; k++) begin
            if (word == W_SEL0 + WORD_AW'(k)) rdata = sel_q[k];
        end
        for (int s = 0; s < NUM_SNS; s++) begin
            if (word == W_SNS0 + WORD_AW'(s)) rdata = sns_q[s];
        end
    end

    // Field unpacking: four select bytes per word, sixteen sense pairs per word.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_fields
        assign sel_o[c]   = sel_t'(sel_q[c / 4][8 * (c % 4) +: 8]);
        assign sense_o[c] = sns_q[c / 16][2 * (c % 16) +: 2];
    end

endmodule

// File: rtl/pirq_chan.sv
module pirq_chan
    import pirq_pkg::*;
#(
    parameter int GPIO_W = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [GPIO_W-1:0] gpio_i,
    input  sel_t              sel_i,
    input  logic [1:0]        sense_i,
    output logic              ev_o
);

    logic [MAX_LINES-1:0] pad;
    logic                 line;
    logic                 hist_q;
    logic [SRC_W-1:0]     src_q;
    logic                 armed;

    assign pad  = MAX_LINES'(gpio_i);
    assign line = pad[sel_i.src];

    // History always follows the selected line; it only counts as a valid
    // previous sample when the channel is enabled and the source is unchanged.
    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= 1'b0;
            src_q  <= '0;
        end else begin
            hist_q <= line;
            src_q  <= sel_i.src;
        end
    end

    assign armed = sel_i.en && (sel_i.src == src_q);
    assign ev_o  = sense_hit(sense_e'(sense_i), sel_i.en, armed, line, hist_q);

endmodule

// File: rtl/pirq_status.sv
module pirq_status #(
    parameter int NUM_CH = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] ev_i,
    input  logic              we_i,
    input  logic [NUM_CH-1:0] keep_i,
    output logic [NUM_CH-1:0] stat_o
);

    logic [NUM_CH-1:0] stat_q;
    logic [NUM_CH-1:0] kept;

    assign kept = we_i ? (stat_q & keep_i) : stat_q;

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= kept | ev_i;
    end

    assign stat_o = stat_q;

endmodule

// File: rtl/pirq_router.sv
module pirq_router
    import pirq_pkg::*;
#(
    parameter int NUM_CH = 32,
    parameter int GPIO_W = 128
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [WORD_AW-1:0] reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [GPIO_W-1:0]  gpio_in,
    output logic [NUM_CH-1:0]  irq_out
);

    sel_t [NUM_CH-1:0]      chan_sel;
    logic [NUM_CH-1:0][1:0] chan_sense;
    logic [NUM_CH-1:0]      chan_ev;
    logic [NUM_CH-1:0]      chan_en;
    logic [NUM_CH-1:0]      stat;
    logic                   stat_we;

    pirq_regs #(.NUM_CH(NUM_CH)) i_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr),
        .word    (reg_addr),
        .wdata   (reg_wdata),
        .stat_i  (stat),
        .rdata   (reg_rdata),
        .stat_we (stat_we),
        .sel_o   (chan_sel),
        .sense_o (chan_sense)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        assign chan_en[c] = chan_sel[c].en;
        pirq_chan #(.GPIO_W(GPIO_W)) i_chan (
            .clk     (clk),
            .rst     (rst),
            .gpio_i  (gpio_in),
            .sel_i   (chan_sel[c]),
            .sense_i (chan_sense[c]),
            .ev_o    (chan_ev[c])
        );
    end

    pirq_status #(.NUM_CH(NUM_CH)) i_status (
        .clk    (clk),
        .rst    (rst),
        .ev_i   (chan_ev),
        .we_i   (stat_we),
        .keep_i (reg_wdata[NUM_CH-1:0]),
        .stat_o (stat)
    );

    assign irq_out = stat;

endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk
    import pirq_pkg::*;
#(
    parameter int NUM_CH = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               reg_wr,
    input logic [WORD_AW-1:0] reg_addr,
    input logic [31:0]        reg_wdata,
    input logic [NUM_CH-1:0]  irq_out,
    input logic [NUM_CH-1:0]  chan_ev,
    input logic [NUM_CH-1:0]  chan_en
);

    logic              past_ok;
    logic [NUM_CH-1:0] clr_mask;

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    assign clr_mask = (reg_wr && reg_addr == W_STAT) ? ~reg_wdata[NUM_CH-1:0] : '0;

    // R1
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (irq_out == '0));

    // R3
    a_r3_disabled_silent: assert property (@(posedge clk) disable iff (rst)
        ((chan_ev & ~chan_en) == '0));

    // R8: a request only appears after an event
    a_r8_set_needs_event: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> ((irq_out & ~$past(irq_out) & ~$past(chan_ev)) == '0));

    // R8: a request only drops after a zero was written to its bit
    a_r8_hold_unless_cleared: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (($past(irq_out) & ~$past(clr_mask) & ~irq_out) == '0));

    // R9
    a_r9_event_wins: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> ((~irq_out & $past(chan_ev)) == '0));

endmodule

bind pirq_router pirq_router_chk #(.NUM_CH(NUM_CH)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .irq_out   (irq_out),
    .chan_ev   (chan_ev),
    .chan_en   (chan_en)
);

// File: tb/test_pirq_router.sv
module test_pirq_router;

    localparam logic [1:0] OP_W = 2'd0;
    localparam logic [1:0] OP_G = 2'd1;
    localparam logic [1:0] OP_C = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VECS [NV] = '{
        '{OP_W, 8'h0C, 32'h0000_0085, 4'd3},   // R3 ch0 on line 5, enabled
        '{OP_C, 8'h00, 32'h0000_0000, 4'd3},
        '{OP_G, 8'd5,  32'h1,         4'd4},
        '{OP_C, 8'h00, 32'h0000_0001, 4'd4},   // R4 rising edge
        '{OP_G, 8'd5,  32'h0,         4'd4},
        '{OP_W, 8'h0A, 32'hFFFF_FFFF, 4'd8},
        '{OP_C, 8'h00, 32'h0000_0001, 4'd8},   // R8 writing ones keeps
        '{OP_W, 8'h0A, 32'h0000_0000, 4'd8},
        '{OP_C, 8'h00, 32'h0000_0000, 4'd8},   // R8 zero clears
        '{OP_W, 8'h08, 32'h0000_0001, 4'd5},
        '{OP_G, 8'd5,  32'h1,         4'd5},
        '{OP_C, 8'h00, 32'h0000_0000, 4'd5},   // R5 rising ignored
        '{OP_G, 8'd5,  32'h0,         4'd5},
        '{OP_C, 8'h00, 32'h0000_0001, 4'd5},   // R5 falling edge
        '{OP_W, 8'h0A, 32'h0000_0000, 4'd8},
        '{OP_W, 8'h08, 32'h0000_0002, 4'd6},
        '{OP_C, 8'h00, 32'h0000_0000, 4'd6},
        '{OP_G, 8'd5,  32'h1,         4'd6},
        '{OP_C, 8'h00, 32'h0000_0001, 4'd6},   // R6 high level
        '{OP_W, 8'h0A, 32'h0000_0000, 4'd9},
        '{OP_C, 8'h00, 32'h0000_0001, 4'd9},   // R9 level event beats clear
        '{OP_G, 8'd5,  32'h0,         4'd6},
        '{OP_W, 8'h0A, 32'h0000_0000, 4'd8},
        '{OP_C, 8'h00, 32'h0000_0000, 4'd6},
        '{OP_W, 8'h09, 32'h0000_000C, 4'd12},  // R12 ch17 low level
        '{OP_W, 8'h10, 32'h0000_8A00, 4'd7},   // ch17 on line 10
        '{OP_C, 8'h00, 32'h0000_0000, 4'd7},
        '{OP_C, 8'h00, 32'h0002_0000, 4'd12},  // R12 / R7
        '{OP_G, 8'd10, 32'h1,         4'd7},
        '{OP_C, 8'h00, 32'h0002_0000, 4'd7},   // R7 stays latched
        '{OP_W, 8'h0A, 32'h0000_0000, 4'd8},
        '{OP_C, 8'h00, 32'h0000_0000, 4'd7}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         reg_wr = 1'b0;
    logic [5:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic [127:0] gpio = '0;
    logic [31:0]  irq_out;
    int           tests = 0;
    int           failed = 0;
    logic [31:0]  rv;

    always #10 clk = ~clk;

    pirq_router i_pirq_router (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .gpio_in   (gpio),
        .irq_out   (irq_out)
    );

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            failed++;
            $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic setg(input int idx, input logic v);
        @(negedge clk);
        gpio[idx] = v;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failed++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        check(1, irq_out, 32'h0);                          // R1
        for (int a = 0; a < 20; a++) begin
            rd(6'(a), rv);
            check(1, rv, 32'h0);                           // R1 all words zero
        end

        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            reg_wr = 1'b0;
            case (VECS[i].op)
                OP_W: begin
                    reg_wr = 1'b1;
                    reg_addr = VECS[i].addr[5:0];
                    reg_wdata = VECS[i].data;
                end
                OP_G: gpio[VECS[i].addr[6:0]] = VECS[i].data[0];
                default: check(int'(VECS[i].req), irq_out, VECS[i].data);
            endcase
            @(negedge clk);
        end
        reg_wr = 1'b0;

        // R10: enable ch1 on line 20 already high
        setg(20, 1'b1);
        wr(6'h0C, 32'h0000_9485);
        repeat (3) @(negedge clk);
        check(10, irq_out, 32'h0);
        // R10: switch ch1 to line 31 sitting high
        setg(31, 1'b1);
        wr(6'h0C, 32'h0000_9F85);
        repeat (3) @(negedge clk);
        check(10, irq_out, 32'h0);
        setg(31, 1'b0);
        setg(31, 1'b1);
        @(negedge clk);
        check(3, irq_out, 32'h0000_0002);                  // R3 new line routed

        // R9: edge event and clear in the same cycle
        setg(31, 1'b0);
        wr(6'h0A, 32'h0);
        check(8, irq_out, 32'h0);
        @(negedge clk);
        gpio[31] = 1'b1;
        reg_wr = 1'b1; reg_addr = 6'h0A; reg_wdata = 32'h0;
        @(negedge clk);
        reg_wr = 1'b0;
        check(9, irq_out, 32'h0000_0002);
        rd(6'h0A, rv);
        check(11, rv, irq_out);                            // R11 status read
        check(11, rv, 32'h0000_0002);

        // R3: disabled channel ignores its line
        wr(6'h0C, 32'h0000_1F85);
        wr(6'h0A, 32'h0);
        setg(31, 1'b0);
        setg(31, 1'b1);
        setg(31, 1'b0);
        setg(31, 1'b1);
        @(negedge clk);
        check(3, irq_out, 32'h0);
        rd(6'h0C, rv);
        check(2, rv, 32'h0000_1F85);                       // R2

        // R2 / R12: readback and unmapped word
        wr(6'h13, 32'hA5A5_5A5A);
        rd(6'h13, rv);
        check(2, rv, 32'hA5A5_5A5A);
        rd(6'h00, rv);
        check(2, rv, 32'h0);
        rd(6'h09, rv);
        check(12, rv, 32'h0000_000C);
        rd(6'h08, rv);
        check(2, rv, 32'h0000_0002);

        // R7 then R1: low level on ch17, then reset mid-run
        setg(10, 1'b0);
        @(negedge clk);
        check(7, irq_out, 32'h0002_0000);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(1, irq_out, 32'h0);
        rd(6'h10, rv);
        check(1, rv, 32'h0);
        rst = 1'b0;

        $display("  [TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

endmodule